// File: doc/BRIEF.md
# Packed to Zoned Decimal Converter

This block turns a signed packed-decimal number into zoned-decimal bytes, one digit per clock cycle. A requester presents a packed operand of up to fifteen BCD digits followed by a trailing sign nibble. It also presents a digit count and pulses a start strobe. The block captures the operand and walks from the most significant digit down to the least significant one. It writes one zoned byte per cycle into an output byte array.

Every zoned byte except the final one is the ASCII code of its digit. The final byte carries the digit in its lower nibble and a zone derived from the sign in its upper nibble. Positive sign codes give zone 0xC, negative codes give zone 0xD, and the unsigned code keeps the plain 0x3 zone. Digit nibbles above nine and sign nibbles below 0xA raise an error flag. They do not stop the conversion. A one-cycle done pulse marks the point where the byte array holds the complete result.

Top module: `pzd_conv`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0 and every bit of `zoned_out` is 0.
- R2: A `start` sampled high while idle loads the operand and clears `zoned_out` and `err`. With an effective count of N, the last byte is written N clock edges after the loading edge. `done` is high for exactly the one cycle after that write, and `busy` is low from then on.
- R3: Packed digit k, counted from the least significant digit as k = 0, occupies `packed_in[4k+7:4k+4]`, and the sign nibble occupies `packed_in[3:0]`. Zoned byte k occupies `zoned_out[8k+7:8k]`. Bytes at positions N and above stay 0.
- R4: Each zoned byte k with 0 < k < N equals 0x30 plus digit k.
- R5: A sign nibble of 0xC, 0xA or 0xE (positive) gives byte 0 the value {0xC, digit 0}.
- R6: A sign nibble of 0xD or 0xB (negative) gives byte 0 the value {0xD, digit 0}.
- R7: A sign nibble of 0xF (unsigned) gives byte 0 the value {0x3, digit 0}.
- R8: A digit nibble above 9 sets `err`. That byte is still written as {0x3, nibble}, or as {zone, nibble} for byte 0. The conversion still completes with `done`.
- R9: A sign nibble below 0xA sets `err`, and byte 0 uses the 0x3 zone.
- R10: A `start` received while `busy` is high has no effect on the result, on its timing or on the captured operand.
- R11: A `digit_cnt` of 0 converts exactly one digit, as a count of 1 does.
- R12: Bytes are written from the most significant position down. After the j-th write edge, exactly bytes N-1 down to N-j are filled.
- R13: `err` and `zoned_out` hold their values after `done` until the next accepted `start`. A following conversion with valid nibbles leaves `err` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Conversion request strobe |
| packed_in | input | 64 | Packed operand: digits above a trailing sign nibble |
| digit_cnt | input | 4 | Number of digits to convert (0 treated as 1) |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse: result complete |
| err | output | 1 | An invalid digit or sign nibble was seen |
| zoned_out | output | 120 | Zoned bytes, byte k at bits 8k+7..8k |

## Verification
The bench builds the block with its default of fifteen digits. The widest operand can therefore be converted in full, with every byte lane written. The same build reaches the zero count, which folds to one digit, and the single-digit case where the sign byte is the only write. With the four-bit count at its top value, the clamp and the index width both sit at their edges. Running a conversion of every length from 1 to 15 also checks that the done timing grows by one cycle per digit.

// File: rtl/pzd_pkg.sv
package pzd_pkg;

  localparam logic [3:0] ZONE_PLAIN = 4'h3;
  localparam logic [3:0] ZONE_PLUS  = 4'hC;
  localparam logic [3:0] ZONE_MINUS = 4'hD;

  function automatic logic nib_is_digit(input logic [3:0] n);
    return (n <= 4'd9);
  endfunction

  function automatic logic nib_is_sign(input logic [3:0] n);
    return (n >= 4'hA);
  endfunction

  function automatic logic [3:0] sign_zone(input logic [3:0] s);
    logic [3:0] z;
    case (s)
      4'hA, 4'hC, 4'hE: z = ZONE_PLUS;
      4'hB, 4'hD:       z = ZONE_MINUS;
      default:          z = ZONE_PLAIN;
    endcase
    return z;
  endfunction

  function automatic logic [7:0] make_zoned(input logic [3:0] zone, input logic [3:0] nib);
    return {zone, nib};
  endfunction

endpackage

// File: rtl/pzd_seq.sv
module pzd_seq #(
  parameter int MAX_DIGITS = 15,
  parameter int CW = 4,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] digit_cnt,
  output logic          busy,
  output logic          done,
  output logic          load_ev,
  output logic          write_ev,
  output logic          last_ev,
  output logic [IW-1:0] wr_idx
);

  logic          busy_q;
  logic          done_q;
  logic [IW-1:0] idx_q;
  logic [CW-1:0] eff_cnt;
  logic [CW-1:0] top_idx;

  always_comb begin
    if (digit_cnt == '0)
      eff_cnt = CW'(1);
    else if (int'(digit_cnt) > MAX_DIGITS)
      eff_cnt = CW'(MAX_DIGITS);
    else
      eff_cnt = digit_cnt;
    top_idx = eff_cnt - CW'(1);
  end

  assign load_ev  = start && !busy_q;
  assign write_ev = busy_q;
  assign last_ev  = busy_q && (idx_q == '0);
  assign wr_idx   = idx_q;
  assign busy     = busy_q;
  assign done     = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      done_q <= last_ev;
      if (load_ev) begin
        busy_q <= 1'b1;
        idx_q  <= IW'(top_idx);
      end else if (last_ev) begin
        busy_q <= 1'b0;
      end else if (write_ev) begin
        idx_q <= idx_q - IW'(1);
      end
    end
  end

endmodule

// File: rtl/pzd_pick.sv
module pzd_pick #(
  parameter int MAX_DIGITS = 15,
  parameter int IW = 4,
  parameter int PW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_ev,
  input  logic [PW-1:0] packed_in,
  input  logic [IW-1:0] wr_idx,
  output logic [3:0]    digit_nib,
  output logic [3:0]    sign_nib
);

  logic [PW-1:0] op_q;
  logic [3:0]    lane [MAX_DIGITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      op_q <= '0;
    else if (load_ev)
      op_q <= packed_in;
  end

  for (genvar g = 0; g < MAX_DIGITS; g++) begin : g_lane
    assign lane[g] = op_q[4*(g+1) +: 4];
  end

  assign sign_nib = op_q[3:0];

  always_comb begin
    digit_nib = 4'h0;
    for (int i = 0; i < MAX_DIGITS; i++)
      if (wr_idx == IW'(i))
        digit_nib = lane[i];
  end

endmodule

// File: rtl/pzd_store.sv
module pzd_store #(
  parameter int MAX_DIGITS = 15,
  parameter int IW = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_ev,
  input  logic                    write_ev,
  input  logic [IW-1:0]           wr_idx,
  input  logic [7:0]              wr_byte,
  output logic [8*MAX_DIGITS-1:0] zoned_out
);

  for (genvar g = 0; g < MAX_DIGITS; g++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        byte_q <= '0;
      else if (load_ev)
        byte_q <= '0;
      else if (write_ev && (wr_idx == IW'(g)))
        byte_q <= wr_byte;
    end
    assign zoned_out[8*g +: 8] = byte_q;
  end

endmodule

// File: rtl/pzd_conv.sv
module pzd_conv
  import pzd_pkg::*;
#(
  parameter int MAX_DIGITS = 15,
  localparam int CW = $clog2(MAX_DIGITS + 1),
  localparam int IW = (MAX_DIGITS > 1) ? $clog2(MAX_DIGITS) : 1,
  localparam int PW = 4 * (MAX_DIGITS + 1),
  localparam int ZW = 8 * MAX_DIGITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [PW-1:0] packed_in,
  input  logic [CW-1:0] digit_cnt,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [ZW-1:0] zoned_out
);

  logic          load_ev;
  logic          write_ev;
  logic          last_ev;
  logic [IW-1:0] wr_idx;
  logic [3:0]    digit_nib;
  logic [3:0]    sign_nib;
  logic [3:0]    zone;
  logic [7:0]    wr_byte;
  logic          bad_nib;
  logic          err_q;

  pzd_seq #(.MAX_DIGITS(MAX_DIGITS), .CW(CW), .IW(IW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .digit_cnt(digit_cnt),
    .busy     (busy),
    .done     (done),
    .load_ev  (load_ev),
    .write_ev (write_ev),
    .last_ev  (last_ev),
    .wr_idx   (wr_idx)
  );

  pzd_pick #(.MAX_DIGITS(MAX_DIGITS), .IW(IW), .PW(PW)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_ev  (load_ev),
    .packed_in(packed_in),
    .wr_idx   (wr_idx),
    .digit_nib(digit_nib),
    .sign_nib (sign_nib)
  );

  // Only the final byte takes its zone from the sign.
  assign zone    = last_ev ? sign_zone(sign_nib) : ZONE_PLAIN;
  assign wr_byte = make_zoned(zone, digit_nib);
  assign bad_nib = write_ev &&
                   (!nib_is_digit(digit_nib) || (last_ev && !nib_is_sign(sign_nib)));

  pzd_store #(.MAX_DIGITS(MAX_DIGITS), .IW(IW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_ev  (load_ev),
    .write_ev (write_ev),
    .wr_idx   (wr_idx),
    .wr_byte  (wr_byte),
    .zoned_out(zoned_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      err_q <= 1'b0;
    else if (load_ev)
      err_q <= 1'b0;
    else if (bad_nib)
      err_q <= 1'b1;
  end

  assign err = err_q;

endmodule

// File: rtl/pzd_conv_chk.sv
module pzd_conv_chk #(
  parameter int MAX_DIGITS = 15,
  parameter int CW = 4,
  parameter int ZW = 120
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [CW-1:0] digit_cnt,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [ZW-1:0] zoned_out,
  input logic          load_ev,
  input logic          write_ev,
  input logic          last_ev
);

  logic [CW:0] want_q;
  logic [CW:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_q <= '0;
      seen_q <= '0;
    end else if (load_ev) begin
      want_q <= (digit_cnt == '0) ? (CW+1)'(1) : (CW+1)'(digit_cnt);
      seen_q <= '0;
    end else if (write_ev) begin
      seen_q <= seen_q + (CW+1)'(1);
    end
  end

  // R2: done lasts one cycle
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R2: last write is followed by done
  a_r2_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n) last_ev |=> done && !busy);
  // R2 / R11: number of writes equals the effective count
  a_r11_write_count: assert property (@(posedge clk) disable iff (!rst_n) done |-> seen_q == want_q);
  // R10: a start while busy does not reload
  a_r10_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n) (start && busy) |-> !load_ev);
  // R8 / R9: err only rises after a write
  a_r8_err_source: assert property (@(posedge clk) disable iff (!rst_n) !write_ev |=> !$rose(err));
  // R13: result held while idle
  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n) (!write_ev && !load_ev) |=> $stable(zoned_out) && $stable(err));

endmodule

bind pzd_conv pzd_conv_chk #(.MAX_DIGITS(MAX_DIGITS), .CW(CW), .ZW(ZW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .digit_cnt(digit_cnt),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .zoned_out(zoned_out),
  .load_ev  (load_ev),
  .write_ev (write_ev),
  .last_ev  (last_ev)
);

// File: tb/pzd_conv_test.sv
module pzd_conv_test;

  localparam int ND = 15;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [63:0]  packed_in = '0;
  logic [3:0]   digit_cnt = '0;
  logic         busy, done, err;
  logic [119:0] zoned_out;

  int vectors = 0;
  int misses = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pzd_conv uut (
    .clk(clk), .rst_n(rst_n), .start(start), .packed_in(packed_in),
    .digit_cnt(digit_cnt), .busy(busy), .done(done), .err(err), .zoned_out(zoned_out)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Independent model: zone per sign, ASCII for the other digits.
  function automatic logic [119:0] model(input logic [63:0] p, input int n);
    logic [119:0] r = '0;
    logic [3:0] s = p[3:0];
    int hi;
    hi = (s == 4'hC || s == 4'hA || s == 4'hE) ? 12 : (s == 4'hD || s == 4'hB) ? 13 : 3;
    for (int k = 0; k < n; k++) begin
      int d = (p >> (4 * k + 4)) & 15;
      r[8*k +: 8] = (k == 0) ? 8'((hi << 4) + d) : 8'(48 + d);
    end
    return r;
  endfunction

  function automatic bit model_err(input logic [63:0] p, input int n);
    bit e = (p[3:0] < 4'hA);
    for (int k = 0; k < n; k++)
      if (((p >> (4 * k + 4)) & 15) > 9) e = 1;
    return e;
  endfunction

  task automatic convert(input string req, input logic [63:0] p, input logic [3:0] c);
    int n = (c == 0) ? 1 : int'(c);
    int cyc = 0;
    @(negedge clk);
    packed_in = p; digit_cnt = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " busy after load"}, 128'(busy), 128'(1));
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    check({req, " cycles to done"}, 128'(cyc), 128'(n));
    check({req, " bytes"}, 128'(zoned_out), 128'(model(p, n)));
    check({req, " err"}, 128'(err), 128'(model_err(p, n)));
    @(negedge clk);
    check("R2 done one cycle", 128'(done), 128'(0));
  endtask

  task automatic t_reset();
    check("R1 busy", 128'(busy), 128'(0));
    check("R1 done", 128'(done), 128'(0));
    check("R1 err", 128'(err), 128'(0));
    check("R1 zoned", 128'(zoned_out), 128'(0));
  endtask

  task automatic t_examples();
    convert("R5 R4 R3 positive", 64'h53842C, 4'd5);
    check("R5 literal", 128'(zoned_out), 128'h3533_3834_C2);
    convert("R6 negative", 64'h6071D, 4'd4);
    check("R6 literal", 128'(zoned_out), 128'h3630_37D1);
    convert("R7 unsigned", 64'h907F, 4'd3);
    check("R7 literal", 128'(zoned_out), 128'h393037);
  endtask

  task automatic t_alt_signs();
    convert("R5 sign A", 64'h12A, 4'd2);
    convert("R6 sign B", 64'h45B, 4'd2);
    convert("R5 sign E", 64'h8E, 4'd1);
    check("R5 E zone", 128'(zoned_out[7:0]), 128'hC8);
  endtask

  task automatic t_lengths();
    for (int n = 1; n <= ND; n++)
      convert("R2 length sweep", 64'h1234_5678_9012_345D, 4'(n));
    check("R3 full width top byte", 128'(zoned_out[119:112]), 128'h31);
  endtask

  task automatic t_zero_count();
    convert("R11 count zero", 64'h987C, 4'd0);
    check("R11 upper bytes zero", 128'(zoned_out[119:8]), 128'(0));
  endtask

  task automatic t_bad_digit();
    convert("R8 bad digit", 64'h1A3C, 4'd3);
    check("R8 byte", 128'(zoned_out[23:0]), 128'h313AC3);
    check("R8 err", 128'(err), 128'(1));
    convert("R13 err cleared", 64'h42C, 4'd2);
    check("R13 err low", 128'(err), 128'(0));
  endtask

  task automatic t_bad_sign();
    convert("R9 bad sign", 64'h425, 4'd2);
    check("R9 byte", 128'(zoned_out[15:0]), 128'h3432);
    check("R9 err", 128'(err), 128'(1));
  endtask

  task automatic t_busy_start();
    int cyc = 0;
    @(negedge clk);
    packed_in = 64'h7654C; digit_cnt = 4'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk); cyc++;
    packed_in = 64'h99999999D; digit_cnt = 4'd8; start = 1'b1;
    @(negedge clk); cyc++;
    start = 1'b0;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    check("R10 timing unchanged", 128'(cyc), 128'(4));
    check("R10 result unchanged", 128'(zoned_out), 128'(model(64'h7654C, 4)));
  endtask

  task automatic t_order();
    @(negedge clk);
    packed_in = 64'h4321F; digit_cnt = 4'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R12 after load", 128'(zoned_out), 128'(0));
    @(negedge clk);
    check("R12 after write 1", 128'(zoned_out), 128'h34_000000);
    @(negedge clk);
    check("R12 after write 2", 128'(zoned_out), 128'h3433_0000);
    @(negedge clk); @(negedge clk);
    check("R12 complete", 128'(zoned_out), 128'h3433_3231);
    repeat (3) @(negedge clk);
    check("R13 held", 128'(zoned_out), 128'h3433_3231);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_examples();
    t_alt_signs();
    t_lengths();
    t_zero_count();
    t_bad_digit();
    t_bad_sign();
    t_busy_start();
    t_order();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vectors++;
      misses++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule